// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block gathers level-sensitive interrupt requests from a configurable set of sources and delivers them to a configurable set of targets, called contexts. Each source has a programmable priority. Each context has three things of its own: an enable bitmap, a priority threshold, and a claim/complete register. Each context drives one interrupt line. The line is high whenever some source is eligible for it.

Software reaches the controller through a plain 32-bit word bus. Every access is accepted in the cycle it is presented, and read data is returned combinationally in that same cycle. To service an interrupt, a handler first reads its context's claim register. That read returns the identifier of the best eligible source and holds that source off. After the work is done, the handler writes the same identifier back to the same register to finish it. Identifier 0 means "nothing". Sources are numbered from 1 up to the configured count, which may be at most 1023.

Top module: `plic_core`

## Requirements
- R1: After reset every priority, enable bit and threshold reads 0. No source is pending or in service, every `irqOut` bit is low, and every claim read returns 0.
- R2: The priority of source n (1..NUM_SRC) is at byte address 4*n. It keeps the low PRIO_W bits of a write and reads them back zero-extended. The slot at address 0 (identifier 0) reads 0 and ignores writes.
- R3: The enable bitmap of context c starts at 0x2000 + 0x80*c. Source n is bit (n mod 32) of word (n / 32). Bit 0 of word 0, and any bit that has no source behind it, reads 0.
- R4: The threshold of context c is at 0x200000 + 0x1000*c. It keeps the low PRIO_W bits of a write. The claim/complete register of context c is 4 bytes above the threshold. Read data is valid in the same cycle as `regRdEn`.
- R5: Bit k of `srcLevel` is the request of source k+1. A source is eligible for context c when three conditions hold: it is pending, it is enabled in c, and its priority is strictly above c's threshold. A source with priority 0 is therefore never delivered. `irqOut[c]` is high exactly when some source is eligible for c.
- R6: A claim read returns the eligible source with the highest priority. Among equal priorities, the lowest identifier wins. The read returns 0 when no source is eligible.
- R7: A claim that returns a nonzero identifier clears that source's pending state and puts it in service. While in service, the source cannot become pending again, even if its request stays high.
- R8: Writing the identifier of an in-service source to any context's claim/complete register ends its service. If the source's request is still high, the source is pending again from that same clock edge.
- R9: A completion write is ignored when it names a source that is not in service, or an identifier that is 0 or above NUM_SRC.
- R10: The following are unmapped: any address with a nonzero low two bits, any region of a context at or above NUM_CTX, any enable word beyond the last source, any priority slot above NUM_SRC, and any other offset. Unmapped reads return 0, and unmapped writes change nothing.
- R11: A request that is high for one clock edge, and then drops, stays pending until it is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Write strobe, accepted in the same cycle |
| regRdEn | input | 1 | Read strobe; a read of a claim register has a side effect |
| regAddr | input | ADDR_W | Byte address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational |
| srcLevel | input | NUM_SRC | Level request per source; bit k is source k+1 |
| irqOut | output | NUM_CTX | Interrupt line per context |

## Verification
The bench targets several corner cases:
- Every threshold value is swept over request patterns that mix equal priorities and priority-0 sources. An off-by-one in the comparison, or a tie that breaks toward the higher identifier, changes the sequence of claims.
- A source whose request stays high is claimed twice without a completion in between. A design that does not hold the source off returns the same identifier twice.
- Completions that name an out-of-range identifier, or a pending source that is not in service, are tested. A design that honours them lets that source be claimed again.
- A one-edge request pulse must survive until it is claimed.
- Writes to missing contexts, to words past the last source and to misaligned addresses must leave the live registers untouched.

// File: rtl/plic_pkg.sv
package plic_pkg;
  localparam int CTX_SEL_W  = 8;
  localparam int SRC_SEL_W  = 10;
  localparam int WORD_SEL_W = 5;

  localparam logic [31:0] PRIO_END   = 32'h0000_1000;
  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
  localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
  localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic                  prioWr;
    logic                  prioRd;
    logic                  enWr;
    logic                  enRd;
    logic                  thrWr;
    logic                  thrRd;
    logic                  clmRd;
    logic                  cmpWr;
    logic [CTX_SEL_W-1:0]  ctx;
    logic [SRC_SEL_W-1:0]  src;
    logic [WORD_SEL_W-1:0] word;
  } regStrobe_t;
endpackage

// File: rtl/plic_ctrl.sv
module plic_ctrl
  import plic_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_CTX = 2,
  parameter int ADDR_W  = 24
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strb
);
  localparam int unsigned NWORDS = NUM_SRC / 32 + 1;
  localparam logic [31:0] EN_END  = EN_BASE + 32'(NUM_CTX) * EN_STRIDE;
  localparam logic [31:0] CTX_END = CTX_BASE + 32'(NUM_CTX) * CTX_STRIDE;

  logic [31:0] addr32;
  logic [31:0] enOff;
  logic [31:0] cxOff;

  always_comb begin
    addr32 = 32'(regAddr);
    enOff  = addr32 - EN_BASE;
    cxOff  = addr32 - CTX_BASE;
    strb   = '0;
    if (addr32[1:0] == 2'b00) begin
      if (addr32 < PRIO_END) begin
        if (addr32[31:2] >= 30'd1 && addr32[31:2] <= 30'(NUM_SRC)) begin
          strb.prioWr = regWrEn;
          strb.prioRd = regRdEn;
          strb.src    = SRC_SEL_W'(addr32[31:2]);
        end
      end else if (addr32 >= EN_BASE && addr32 < EN_END) begin
        if (32'(enOff[6:2]) < NWORDS) begin
          strb.enWr = regWrEn;
          strb.enRd = regRdEn;
          strb.ctx  = CTX_SEL_W'(enOff >> 7);
          strb.word = enOff[6:2];
        end
      end else if (addr32 >= CTX_BASE && addr32 < CTX_END) begin
        strb.ctx = CTX_SEL_W'(cxOff >> 12);
        if (cxOff[11:0] == 12'h000) begin
          strb.thrWr = regWrEn;
          strb.thrRd = regRdEn;
        end else if (cxOff[11:0] == 12'h004) begin
          strb.clmRd = regRdEn;
          strb.cmpWr = regWrEn;
        end
      end
    end
  end
endmodule

// File: rtl/plic_dp.sv
module plic_dp
  import plic_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  regStrobe_t         strb,
  input  logic [31:0]        wrData,
  input  logic [NUM_SRC-1:0] srcLevel,
  output logic [31:0]        rdData,
  output logic [NUM_CTX-1:0] irqOut
);
  localparam int ID_W = $clog2(NUM_SRC + 1);

  logic [PRIO_W-1:0]  prio [1:NUM_SRC];
  logic [NUM_SRC:1]   en   [NUM_CTX];
  logic [PRIO_W-1:0]  thr  [NUM_CTX];
  logic [NUM_SRC:1]   pend, inSvc, lvl;
  logic [NUM_SRC:1]   claimHit, compHit, pendN, inSvcN;
  logic [ID_W-1:0]    winId [NUM_CTX];
  logic [ID_W-1:0]    selWin;

  assign lvl = srcLevel;

  // Per-context winner: highest priority, lowest identifier on ties
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_arb
    logic [ID_W-1:0]   win;
    logic [PRIO_W-1:0] bestP;
    always_comb begin
      win   = '0;
      bestP = '0;
      for (int s = 1; s <= NUM_SRC; s++) begin
        if (pend[s] && en[c][s] && prio[s] > thr[c] && prio[s] > bestP) begin
          win   = ID_W'(s);
          bestP = prio[s];
        end
      end
    end
    assign winId[c]  = win;
    assign irqOut[c] = (win != '0);
  end

  always_comb begin
    selWin = '0;
    for (int c = 0; c < NUM_CTX; c++)
      if (strb.ctx == CTX_SEL_W'(c)) selWin = winId[c];
    for (int s = 1; s <= NUM_SRC; s++) begin
      claimHit[s] = strb.clmRd && (selWin == ID_W'(s));
      compHit[s]  = strb.cmpWr && (wrData == 32'(s)) && inSvc[s];
    end
    inSvcN = (inSvc | claimHit) & ~compHit;
    pendN  = (pend & ~claimHit) | (lvl & ~inSvcN);
  end

  always_comb begin
    rdData = '0;
    if (strb.prioRd)
      for (int s = 1; s <= NUM_SRC; s++)
        if (strb.src == SRC_SEL_W'(s)) rdData = 32'(prio[s]);
    if (strb.enRd)
      for (int c = 0; c < NUM_CTX; c++)
        for (int s = 1; s <= NUM_SRC; s++)
          if (strb.ctx == CTX_SEL_W'(c) && strb.word == WORD_SEL_W'(s / 32))
            rdData[s % 32] = en[c][s];
    if (strb.thrRd)
      for (int c = 0; c < NUM_CTX; c++)
        if (strb.ctx == CTX_SEL_W'(c)) rdData = 32'(thr[c]);
    if (strb.clmRd) rdData = 32'(selWin);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 1; s <= NUM_SRC; s++) prio[s] <= '0;
      for (int c = 0; c < NUM_CTX; c++) begin
        en[c]  <= '0;
        thr[c] <= '0;
      end
      pend  <= '0;
      inSvc <= '0;
    end else begin
      if (strb.prioWr)
        for (int s = 1; s <= NUM_SRC; s++)
          if (strb.src == SRC_SEL_W'(s)) prio[s] <= wrData[PRIO_W-1:0];
      if (strb.enWr)
        for (int c = 0; c < NUM_CTX; c++)
          for (int s = 1; s <= NUM_SRC; s++)
            if (strb.ctx == CTX_SEL_W'(c) && strb.word == WORD_SEL_W'(s / 32))
              en[c][s] <= wrData[s % 32];
      if (strb.thrWr)
        for (int c = 0; c < NUM_CTX; c++)
          if (strb.ctx == CTX_SEL_W'(c)) thr[c] <= wrData[PRIO_W-1:0];
      pend  <= pendN;
      inSvc <= inSvcN;
    end
  end
endmodule

// File: rtl/plic_core.sv
module plic_core
  import plic_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic [NUM_SRC-1:0] srcLevel,
  output logic [NUM_CTX-1:0] irqOut
);
  regStrobe_t strb;

  plic_ctrl #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)) u_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  plic_dp #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .wrData   (regWrData),
    .srcLevel (srcLevel),
    .rdData   (regRdData),
    .irqOut   (irqOut)
  );
endmodule

// File: rtl/plic_core_chk.sv
module plic_core_chk #(
  parameter int NUM_SRC = 40,
  parameter int NUM_CTX = 2,
  parameter int ADDR_W  = 24
) (
  input logic               clk,
  input logic               rst,
  input logic               regRdEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [31:0]        regRdData,
  input logic [NUM_CTX-1:0] irqOut
);
  logic clm0Rd;
  logic holeRd;
  assign clm0Rd = regRdEn && (regAddr == ADDR_W'(32'h0020_0004));
  assign holeRd = regRdEn && (regAddr >= ADDR_W'(32'h1000)) && (regAddr < ADDR_W'(32'h2000));

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irqOut == '0));

  p_claim_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (clm0Rd && !irqOut[0]) |-> (regRdData == 32'd0));

  p_claim_valid_r5: assert property (@(posedge clk) disable iff (rst)
    (clm0Rd && irqOut[0]) |-> (regRdData != 32'd0 && regRdData <= 32'(NUM_SRC)));

  p_hold_off_r7: assert property (@(posedge clk) disable iff (rst)
    (clm0Rd && regRdData != 32'd0) |=> (!clm0Rd || regRdData != $past(regRdData)));

  p_hole_zero_r10: assert property (@(posedge clk) disable iff (rst)
    holeRd |-> (regRdData == 32'd0));
endmodule

bind plic_core plic_core_chk #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .regRdEn   (regRdEn),
  .regAddr   (regAddr),
  .regRdData (regRdData),
  .irqOut    (irqOut)
);

// File: tb/test_plic_core.sv
`timescale 1ns/1ps
module test_plic_core;
  localparam int N  = 40;
  localparam int C  = 2;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          regWrEn = 1'b0, regRdEn = 1'b0;
  logic [23:0]   regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic [N-1:0]  srcLevel = '0;
  logic [C-1:0]  irqOut;

  int nChk = 0, nErr = 0;
  bit done = 0;

  int mPrio [1:N];
  bit mEn   [C][1:N];
  int mThr  [C];
  bit mPend [1:N];
  bit mSvc  [1:N];
  bit mLvl  [1:N];

  always #4 clk = ~clk;

  plic_core #(.NUM_SRC(N), .NUM_CTX(C), .PRIO_W(PW), .ADDR_W(24)) i_plic_core (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .srcLevel(srcLevel), .irqOut(irqOut)
  );

  function automatic int aEn(int c, int w);  return 32'h2000 + 32'h80 * c + 4 * w; endfunction
  function automatic int aThr(int c);        return 32'h20_0000 + 32'h1000 * c; endfunction
  function automatic int aClm(int c);        return aThr(c) + 4; endfunction

  function automatic int expWin(int c);
    int b = 0, bp = 0;
    for (int s = 1; s <= N; s++)
      if (mPend[s] && mEn[c][s] && mPrio[s] > mThr[c] && mPrio[s] > bp) begin
        b = s; bp = mPrio[s];
      end
    return b;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); regWrEn = 1; regAddr = 24'(a); regWrData = d;
    @(posedge clk); #1 regWrEn = 0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk); regRdEn = 1; regAddr = 24'(a);
    #1 d = regRdData;
    @(posedge clk); #1 regRdEn = 0;
  endtask

  task automatic rdChk(int a, int exp, string tag);
    int d;
    rd(a, d);
    chk(d == exp, tag, d, exp);
  endtask

  task automatic setLvl(logic [N-1:0] v);
    @(negedge clk); srcLevel = v;
    @(posedge clk); #1;
    for (int s = 1; s <= N; s++) begin
      mLvl[s] = v[s-1];
      if (mLvl[s] && !mSvc[s]) mPend[s] = 1;
    end
  endtask

  task automatic claim(int c, string tag, output int got);
    int e;
    e = expWin(c);
    rd(aClm(c), got);
    chk(got == e, tag, got, e);
    if (e != 0) begin mPend[e] = 0; mSvc[e] = 1; end
  endtask

  task automatic complete(int c, int id);
    wr(aClm(c), id);
    if (id >= 1 && id <= N && mSvc[id]) begin
      mSvc[id] = 0;
      if (mLvl[id]) mPend[id] = 1;
    end
  endtask

  task automatic chkIrq(string tag);
    for (int c = 0; c < C; c++)
      chk(irqOut[c] == (expWin(c) != 0), tag, irqOut[c], expWin(c) != 0);
  endtask

  task automatic drain(int c, string tag);
    int got [64];
    int n = 0, g;
    for (int k = 0; k <= N; k++) begin
      claim(c, tag, g);
      if (g == 0) break;
      got[n] = g; n++;
    end
    chk(irqOut[c] == 1'b0, "R7 line low after drain", irqOut[c], 0);
    for (int k = 0; k < n; k++) complete(c, got[k]);
    chkIrq("R8 after completions");
  endtask

  task automatic setEn(int c, int w, int v);
    wr(aEn(c, w), v);
    for (int s = 1; s <= N; s++)
      if (s / 32 == w) mEn[c][s] = v[s % 32];
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nErr++; nChk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end

  initial begin
    int g;
    for (int s = 1; s <= N; s++) begin mPrio[s] = 0; mPend[s] = 0; mSvc[s] = 0; mLvl[s] = 0; end
    for (int c = 0; c < C; c++) begin
      mThr[c] = 0;
      for (int s = 1; s <= N; s++) mEn[c][s] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;

    // R1: reset state
    chk(irqOut == '0, "R1 irq", irqOut, 0);
    for (int s = 1; s <= N; s++) rdChk(4 * s, 0, "R1 prio");
    for (int c = 0; c < C; c++) begin
      rdChk(aEn(c, 0), 0, "R1 en0"); rdChk(aEn(c, 1), 0, "R1 en1");
      rdChk(aThr(c), 0, "R1 thr"); rdChk(aClm(c), 0, "R1 claim");
    end

    // R2: priority registers, slot 0 reserved
    for (int s = 0; s <= N; s++) begin
      wr(4 * s, s * 7 + 32'hF0);
      if (s >= 1) mPrio[s] = (s * 7 + 32'hF0) & 7;
    end
    for (int s = 0; s <= N; s++) rdChk(4 * s, (s == 0) ? 0 : mPrio[s], "R2 prio readback");
    rdChk(4 * (N + 1), 0, "R10 prio past last");

    // R3: enable bitmaps
    setEn(0, 0, 32'hFFFF_FFFF); setEn(0, 1, 32'hFFFF_FFFF);
    setEn(1, 0, 32'hA5A5_A5A5); setEn(1, 1, 32'h5A5A_5A5A);
    rdChk(aEn(0, 0), 32'hFFFF_FFFE, "R3 ctx0 w0");
    rdChk(aEn(0, 1), 32'h0000_01FF, "R3 ctx0 w1");
    rdChk(aEn(1, 0), 32'hA5A5_A5A4, "R3 ctx1 w0");
    rdChk(aEn(1, 1), 32'h0000_005A, "R3 ctx1 w1");

    // R4: thresholds
    wr(aThr(1), 32'hFD); mThr[1] = 5;
    rdChk(aThr(1), 5, "R4 thr1");
    rdChk(aThr(0), 0, "R4 thr0");

    // R10: unmapped writes and reads
    wr(aEn(0, 2), 32'hFFFF_FFFF); wr(aEn(2, 0), 32'hFFFF_FFFF);
    wr(aThr(2), 7); wr(aThr(0) + 8, 7); wr(aThr(0) + 1, 7); wr(32'h1000, 7); wr(5, 7);
    rdChk(aEn(0, 2), 0, "R10 en word past last"); rdChk(aEn(2, 0), 0, "R10 missing ctx en");
    rdChk(aThr(2), 0, "R10 missing ctx thr"); rdChk(aThr(0) + 8, 0, "R10 ctx hole");
    rdChk(aThr(0) + 1, 0, "R10 misaligned"); rdChk(32'h1000, 0, "R10 gap");
    rdChk(aThr(0), 0, "R10 thr0 untouched"); rdChk(4, mPrio[1], "R10 prio1 untouched");
    chk(irqOut == '0, "R10 irq quiet", irqOut, 0);

    // R5/R6/R8: sweep every threshold over varied request patterns
    for (int t = 0; t < 8; t++) begin
      wr(aThr(0), t); mThr[0] = t;
      setLvl(N'(64'hD1B5_4A32_D192_ED03 * (t + 1) >> 7));
      chkIrq("R5 eligibility");
      drain(0, "R6 claim order");
      setLvl('0);
      chkIrq("R11 latched after drop");
    end
    wr(aThr(0), 0); mThr[0] = 0;
    drain(0, "R6 cleanup");

    // R7/R9/R8: hold-off and ignored completions
    setLvl('1);
    claim(0, "R6 top priority", g); chk(g == 1, "R6 id1 first", g, 1);
    claim(0, "R7 held off", g);     chk(g == 9, "R7 next tie winner", g, 9);
    complete(0, N + 1); complete(0, 0); complete(0, 17);
    claim(0, "R9 ignored completion", g); chk(g == 17, "R9 id17 still pending", g, 17);
    complete(0, 1);
    claim(0, "R8 repend", g); chk(g == 1, "R8 id1 again", g, 1);
    complete(1, 1); complete(0, 9); complete(0, 17);
    setLvl('0);
    drain(0, "R6 cleanup");

    // R11: single-edge pulse
    setLvl(N'(1) << 2); setLvl('0);
    claim(0, "R11 pulse", g); chk(g == 3, "R11 pulse kept", g, 3);
    complete(0, 3);
    claim(0, "R8 no repend when low", g); chk(g == 0, "R8 none left", g, 0);

    // R5: context isolation, threshold boundary, priority 0
    setEn(0, 0, 0); setEn(0, 1, 0);
    setLvl(N'(1) << 1);
    chk(irqOut == 2'b10, "R5 only ctx1", irqOut, 2);
    wr(aThr(1), 6); mThr[1] = 6; #1;
    chk(irqOut[1] == 1'b0, "R5 prio equal threshold", irqOut[1], 0);
    wr(aThr(1), 5); mThr[1] = 5; #1;
    chk(irqOut[1] == 1'b1, "R5 prio above threshold", irqOut[1], 1);
    claim(0, "R5 ctx0 disabled", g); chk(g == 0, "R5 ctx0 empty", g, 0);
    claim(1, "R5 ctx1 claim", g);    chk(g == 2, "R5 ctx1 gets 2", g, 2);
    complete(1, 2); setLvl('0); drain(1, "R6 cleanup");
    setEn(0, 0, 32'hFFFF_FFFF); setEn(0, 1, 32'hFFFF_FFFF);
    drain(0, "R6 cleanup");
    setLvl(N'(1) << 7);
    chk(irqOut[0] == 1'b0, "R5 prio0 never", irqOut[0], 0);
    claim(0, "R5 prio0 claim", g); chk(g == 0, "R5 prio0 claim zero", g, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule